// File: doc/BRIEF.md
# Alt-Mode Lane Crosspoint Mode Controller

This block is the control logic of a sink-side USB Type-C alternate-mode lane switch. It reads two mode-select control pins and a plug-orientation pin, or register copies of the two mode bits when the register interface is strapped on. From these it produces registered routing selects for the two connector lane-pair groups, a USB SuperSpeed path enable, four DisplayPort lane enables, and the two closures that connect the AUX pair to one of the two sideband pins.

Three modes route traffic: USB only, USB plus two DisplayPort lanes, and four DisplayPort lanes. The orientation pin sets which connector group carries USB and which carries DisplayPort lanes 0/1. It also sets which sideband pin receives the AUX pair. In register mode the DP lane enables come from one of two sources, selected by a register bit: a snooped sink power state, or per-lane disable bits. The AUX closure turns on at once and turns off after a debounce window. A fall of the effective USB mode bit produces a USB path reset pulse.

Top module: `altx_ctrl`

## Requirements
- R1: While reset is asserted, and at its release, every output is 0.
- R2: Mode bits {ctl1,ctl0}=01 select USB only. usb_en=1. The USB group carries select code 3'b001 and the other group carries 3'b000. All DP lane enables are 0.
- R3: Mode bits 11 select USB plus two DP lanes. The USB group carries 3'b001 and the other group carries 3'b010 (DP lanes 0/1). Only DP lane enables 0 and 1 can be set.
- R4: Mode bits 10 select four DP lanes with usb_en=0. Group A carries 3'b100 (lanes 2/3) and group B carries 3'b010 when not flipped. All four lane enables can be set.
- R5: Mode bits 00 drive both group selects, usb_en and all lane enables to 0.
- R6: When the orientation is flipped (flip=1), the contents of group A and group B are swapped. The AUX closure moves from aux_sbu_a to aux_sbu_b. The two closures are never both on.
- R7: With cfg_reg_en=1, the mode bits come from reg_ctl0/reg_ctl1 and the two control pins have no effect.
- R8: Each pin passes through SYNC_STAGES flip-flops and then the output register. A pin change appears on the outputs SYNC_STAGES+1 clock edges later. A register-bit change appears 1 edge later.
- R9: The AUX closure turns on at the same update that shows ctl1=1. After the first update that shows ctl1=0, it stays on for DB_CYCLES further edges and then turns off. A return of ctl1 within that window keeps it on and restarts the window.
- R10: With cfg_reg_en=0, every lane that the mode uses is enabled, whatever the snoop and lane-disable inputs are.
- R11: With cfg_reg_en=1 and snoop_en=1, the lanes that the mode uses are enabled only when snoop_pwr equals 3'b001 (normal power state). Otherwise all lanes are off.
- R12: With cfg_reg_en=1 and snoop_en=0, lane i is enabled exactly when the mode uses it and lane_dis[i]=0.
- R13: usb_path_rst pulses for one cycle on the update where the effective ctl0 changes from 1 to 0. That sequence (low, high, low) is the USB path reset, and usb_en is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl0_pin | input | 1 | USB mode control pin (asynchronous) |
| ctl1_pin | input | 1 | DP mode control pin (asynchronous) |
| flip_pin | input | 1 | Plug orientation pin (asynchronous) |
| cfg_reg_en | input | 1 | Strap: mode bits taken from registers, snoop logic active |
| reg_ctl0 | input | 1 | Register copy of the USB mode bit |
| reg_ctl1 | input | 1 | Register copy of the DP mode bit |
| snoop_en | input | 1 | Lane enables follow the snooped power state |
| snoop_pwr | input | 3 | Snooped sink power-state value |
| lane_dis | input | 4 | Per-lane DP disable bits |
| grp_a_sel | output | 3 | Group A select: bit0 USB, bit1 DP0/1, bit2 DP2/3 |
| grp_b_sel | output | 3 | Group B select, same encoding |
| usb_en | output | 1 | USB SuperSpeed path enable |
| dp_lane_en | output | 4 | DP lane enables |
| aux_sbu_a | output | 1 | AUX pair to sideband pin A |
| aux_sbu_b | output | 1 | AUX pair to sideband pin B |
| usb_path_rst | output | 1 | One-cycle USB path reset pulse |

## Verification
The hardest situation to reach is a return of ctl1 in the middle of the AUX turn-off window. The stimulus lets the window run part way, raises and drops the register copy of ctl1 again, and then counts edges until the closure opens. The full decode of flip, mode, snoop source, power value and disable bits is swept in register mode, so the result appears one edge after each change. A shorter pin-mode sweep holds the disable and snoop inputs at adverse values to show that they are ignored there.

// File: rtl/altx_pkg.sv
package altx_pkg;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_USB    = 2'b01,
      MODE_DP4    = 2'b10,
      MODE_USBDP2 = 2'b11
   } altx_mode_e;

   localparam int GSEL_W = 3;
   typedef logic [GSEL_W-1:0] gsel_t;
   localparam gsel_t GSEL_NONE = 3'b000;
   localparam gsel_t GSEL_USB  = 3'b001;
   localparam gsel_t GSEL_DPLO = 3'b010;
   localparam gsel_t GSEL_DPHI = 3'b100;

   localparam int DP_LANES = 4;
endpackage

// File: rtl/altx_sync.sv
module altx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("altx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/altx_route.sv
module altx_route
   import altx_pkg::*;
(
   input  altx_mode_e          mode,
   input  logic                flip,
   output gsel_t               grp_a,
   output gsel_t               grp_b,
   output logic                usb_on,
   output logic [DP_LANES-1:0] dp_mask
);
   gsel_t near_sel, far_sel;

   always_comb begin
      near_sel = GSEL_NONE;
      far_sel  = GSEL_NONE;
      usb_on   = 1'b0;
      dp_mask  = '0;
      unique case (mode)
         MODE_USB: begin
            near_sel = GSEL_USB;
            usb_on   = 1'b1;
         end
         MODE_USBDP2: begin
            near_sel = GSEL_USB;
            far_sel  = GSEL_DPLO;
            usb_on   = 1'b1;
            dp_mask  = 4'b0011;
         end
         MODE_DP4: begin
            near_sel = GSEL_DPHI;
            far_sel  = GSEL_DPLO;
            dp_mask  = 4'b1111;
         end
         default: ;
      endcase
      grp_a = flip ? far_sel  : near_sel;
      grp_b = flip ? near_sel : far_sel;
   end

   always_comb begin
      assert ($onehot0(grp_a) && $onehot0(grp_b)); // p_sel_onehot_r6
   end
endmodule

// File: rtl/altx_lane_en.sv
module altx_lane_en #(
   parameter int              LANES  = 4,
   parameter int              PWR_W  = 3,
   parameter logic [PWR_W-1:0] PWR_ON = 3'b001
) (
   input  logic [LANES-1:0] mask,
   input  logic             reg_mode,
   input  logic             snoop_en,
   input  logic [PWR_W-1:0] snoop_pwr,
   input  logic [LANES-1:0] lane_dis,
   output logic [LANES-1:0] lane_en
);
   if (LANES < 1 || PWR_W < 1) begin : g_bad_cfg
      $error("altx_lane_en: LANES and PWR_W must be positive");
   end

   logic pwr_ok;
   assign pwr_ok = (snoop_pwr == PWR_ON);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         if (!reg_mode)     lane_en[i] = mask[i];
         else if (snoop_en) lane_en[i] = mask[i] & pwr_ok;
         else               lane_en[i] = mask[i] & ~lane_dis[i];
      end
   end
endmodule

// File: rtl/altx_aux_db.sv
module altx_aux_db #(
   parameter int DB_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_req,
   output logic aux_on
);
   if (DB_CYCLES < 1) begin : g_bad_db
      $error("altx_aux_db: DB_CYCLES must be at least 1");
   end

   localparam int CW = $clog2(DB_CYCLES + 1);
   localparam logic [CW-1:0] CMAX = CW'(DB_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_on <= 1'b0;
         cnt    <= '0;
      end else if (dp_req) begin
         aux_on <= 1'b1;
         cnt    <= '0;
      end else if (aux_on) begin
         if (cnt == CMAX) begin
            aux_on <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_db_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CMAX);
   p_aux_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dp_req |=> aux_on);
   p_aux_idle_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_on |-> (cnt == '0));
endmodule

// File: rtl/altx_ctrl.sv
module altx_ctrl
   import altx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DB_CYCLES   = 16,
   parameter int PWR_W       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl0_pin,
   input  logic                ctl1_pin,
   input  logic                flip_pin,
   input  logic                cfg_reg_en,
   input  logic                reg_ctl0,
   input  logic                reg_ctl1,
   input  logic                snoop_en,
   input  logic [PWR_W-1:0]    snoop_pwr,
   input  logic [DP_LANES-1:0] lane_dis,
   output logic [GSEL_W-1:0]   grp_a_sel,
   output logic [GSEL_W-1:0]   grp_b_sel,
   output logic                usb_en,
   output logic [DP_LANES-1:0] dp_lane_en,
   output logic                aux_sbu_a,
   output logic                aux_sbu_b,
   output logic                usb_path_rst
);
   localparam int PIN_W = 3;

   logic [PIN_W-1:0] pin_sync;
   altx_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({flip_pin, ctl1_pin, ctl0_pin}),
      .q    (pin_sync)
   );

   logic       eff_ctl0, eff_ctl1, eff_flip;
   altx_mode_e eff_mode;
   assign eff_ctl0 = cfg_reg_en ? reg_ctl0 : pin_sync[0];
   assign eff_ctl1 = cfg_reg_en ? reg_ctl1 : pin_sync[1];
   assign eff_flip = pin_sync[2];
   assign eff_mode = altx_mode_e'({eff_ctl1, eff_ctl0});

   gsel_t               nxt_a, nxt_b;
   logic                nxt_usb;
   logic [DP_LANES-1:0] nxt_mask, nxt_lanes;

   altx_route u_route (
      .mode   (eff_mode),
      .flip   (eff_flip),
      .grp_a  (nxt_a),
      .grp_b  (nxt_b),
      .usb_on (nxt_usb),
      .dp_mask(nxt_mask)
   );

   altx_lane_en #(.LANES(DP_LANES), .PWR_W(PWR_W)) u_lanes (
      .mask     (nxt_mask),
      .reg_mode (cfg_reg_en),
      .snoop_en (snoop_en),
      .snoop_pwr(snoop_pwr),
      .lane_dis (lane_dis),
      .lane_en  (nxt_lanes)
   );

   logic aux_on;
   altx_aux_db #(.DB_CYCLES(DB_CYCLES)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .dp_req(eff_ctl1),
      .aux_on(aux_on)
   );

   logic ctl0_q, flip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_a_sel    <= GSEL_NONE;
         grp_b_sel    <= GSEL_NONE;
         usb_en       <= 1'b0;
         dp_lane_en   <= '0;
         ctl0_q       <= 1'b0;
         flip_q       <= 1'b0;
         usb_path_rst <= 1'b0;
      end else begin
         grp_a_sel    <= nxt_a;
         grp_b_sel    <= nxt_b;
         usb_en       <= nxt_usb;
         dp_lane_en   <= nxt_lanes;
         ctl0_q       <= eff_ctl0;
         flip_q       <= eff_flip;
         usb_path_rst <= ctl0_q & ~eff_ctl0;
      end
   end

   assign aux_sbu_a = aux_on & ~flip_q;
   assign aux_sbu_b = aux_on &  flip_q;

   p_usb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(grp_a_sel[0] && grp_b_sel[0]));
   p_usb_en_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      usb_en == (grp_a_sel[0] | grp_b_sel[0]));
   p_aux_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(aux_sbu_a && aux_sbu_b));
   p_hi_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|dp_lane_en[3:2]) |-> (grp_a_sel[2] | grp_b_sel[2]));
   p_lo_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|dp_lane_en[1:0]) |-> (grp_a_sel[1] | grp_b_sel[1]));
   p_rst_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      usb_path_rst |=> !usb_path_rst);
   p_rst_no_usb_r13: assert property (@(posedge clk) disable iff (!rst_n)
      usb_path_rst |-> !usb_en);
endmodule

// File: tb/sim_altx_ctrl.sv
`timescale 1ns/1ps
module sim_altx_ctrl;
   localparam int DB = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl0_pin = 0, ctl1_pin = 0, flip_pin = 0, cfg_reg_en = 0;
   logic reg_ctl0 = 0, reg_ctl1 = 0, snoop_en = 0;
   logic [2:0] snoop_pwr = 0;
   logic [3:0] lane_dis = 0;
   logic [2:0] grp_a_sel, grp_b_sel;
   logic       usb_en, aux_sbu_a, aux_sbu_b, usb_path_rst;
   logic [3:0] dp_lane_en;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   altx_ctrl #(.SYNC_STAGES(2), .DB_CYCLES(DB)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl0_pin(ctl0_pin), .ctl1_pin(ctl1_pin),
      .flip_pin(flip_pin), .cfg_reg_en(cfg_reg_en), .reg_ctl0(reg_ctl0),
      .reg_ctl1(reg_ctl1), .snoop_en(snoop_en), .snoop_pwr(snoop_pwr),
      .lane_dis(lane_dis), .grp_a_sel(grp_a_sel), .grp_b_sel(grp_b_sel),
      .usb_en(usb_en), .dp_lane_en(dp_lane_en), .aux_sbu_a(aux_sbu_a),
      .aux_sbu_b(aux_sbu_b), .usb_path_rst(usb_path_rst));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // packed {grp_a[2:0], grp_b[2:0], usb, lanes[3:0]}
   function automatic logic [10:0] model(input bit fl, input int m, input bit regm,
                                         input bit se, input int sp,
                                         input logic [3:0] ld);
      logic [2:0] nr, fr;
      logic [3:0] mask, ln;
      bit u;
      u    = (m == 1) || (m == 3);
      nr   = u ? 3'b001 : ((m == 2) ? 3'b100 : 3'b000);
      fr   = (m >= 2) ? 3'b010 : 3'b000;
      mask = (m == 2) ? 4'b1111 : ((m == 3) ? 4'b0011 : 4'b0000);
      if (!regm)   ln = mask;
      else if (se) ln = (sp == 1) ? mask : 4'b0000;
      else         ln = mask & ~ld;
      return fl ? {fr, nr, u, ln} : {nr, fr, u, ln};
   endfunction

   function automatic logic [10:0] obs();
      return {grp_a_sel, grp_b_sel, usb_en, dp_lane_en};
   endfunction

   function automatic string rq(input int m, input bit regm, input bit se);
      if (!regm) return (m == 0) ? "R5" : "R10";
      if (m == 0) return "R5";
      if (m == 1) return "R2";
      if (se) return "R11";
      return (m == 3) ? "R3" : "R12";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [10:0] e;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(obs() == 0 && !aux_sbu_a && !aux_sbu_b && !usb_path_rst, "R1",
          {aux_sbu_a, aux_sbu_b, usb_path_rst, obs()}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(obs() == 0 && !aux_sbu_a && !aux_sbu_b, "R1", obs(), 0);

      // register-mode sweep: R2 R3 R4 R5 R6 R11 R12
      cfg_reg_en = 1'b1;
      for (int fl = 0; fl < 2; fl++) begin
         flip_pin = fl[0];
         repeat (4) @(negedge clk);
         for (int m = 0; m < 4; m++)
            for (int se = 0; se < 2; se++)
               for (int sp = 0; sp < 8; sp++)
                  for (int ld = 0; ld < 16; ld++) begin
                     {reg_ctl1, reg_ctl0} = m[1:0];
                     snoop_en = se[0]; snoop_pwr = sp[2:0]; lane_dis = ld[3:0];
                     @(negedge clk);
                     e = model(fl[0], m, 1'b1, se[0], sp, ld[3:0]);
                     chk(obs() == e, fl ? "R6" : rq(m, 1'b1, se[0]), obs(), e);
                  end
      end

      // pin mode: R10 R4 R6, disables and bad snoop held
      cfg_reg_en = 1'b0; lane_dis = 4'hF; snoop_en = 1'b1; snoop_pwr = 3'd2;
      for (int fl = 0; fl < 2; fl++)
         for (int m = 0; m < 4; m++) begin
            flip_pin = fl[0]; {ctl1_pin, ctl0_pin} = m[1:0];
            repeat (4) @(negedge clk);
            e = model(fl[0], m, 1'b0, 1'b1, 2, 4'hF);
            chk(obs() == e, rq(m, 1'b0, 1'b1), obs(), e);
         end

      // R8: pin latency SYNC_STAGES+1 edges (currently flip=1, mode 11)
      {ctl1_pin, ctl0_pin} = 2'b01; flip_pin = 1'b0;
      repeat (2) @(negedge clk);
      e = model(1'b1, 3, 1'b0, 1'b1, 2, 4'hF);
      chk(obs() == e, "R8 early", obs(), e);
      @(negedge clk);
      e = model(1'b0, 1, 1'b0, 1'b1, 2, 4'hF);
      chk(obs() == e, "R8 late", obs(), e);

      // R7: pins ignored in register mode
      cfg_reg_en = 1'b1; snoop_en = 1'b0; lane_dis = 4'h0;
      {reg_ctl1, reg_ctl0} = 2'b01;
      @(negedge clk);
      {ctl1_pin, ctl0_pin} = 2'b10;
      repeat (4) @(negedge clk);
      e = model(1'b0, 1, 1'b1, 1'b0, 0, 4'h0);
      chk(obs() == e && !usb_path_rst, "R7", obs(), e);
      {ctl1_pin, ctl0_pin} = 2'b00;
      repeat (4) @(negedge clk);
      chk(obs() == e && !usb_path_rst, "R7", obs(), e);

      // R13: ctl0 fall gives one pulse
      {reg_ctl1, reg_ctl0} = 2'b00;
      @(negedge clk);
      chk(usb_path_rst == 1'b1 && usb_en == 1'b0, "R13", {usb_path_rst, usb_en}, 2'b10);
      @(negedge clk);
      chk(usb_path_rst == 1'b0, "R13", usb_path_rst, 0);
      {reg_ctl1, reg_ctl0} = 2'b01;
      @(negedge clk);
      chk(usb_path_rst == 1'b0, "R13 rise", usb_path_rst, 0);
      {reg_ctl1, reg_ctl0} = 2'b11;
      @(negedge clk);
      {reg_ctl1, reg_ctl0} = 2'b10;
      @(negedge clk);
      chk(usb_path_rst == 1'b1, "R13 11to10", usb_path_rst, 1);

      // R9: aux debounce (flip=0, aux on)
      @(negedge clk);
      chk(aux_sbu_a && !aux_sbu_b, "R9 on", {aux_sbu_a, aux_sbu_b}, 2'b10);
      {reg_ctl1, reg_ctl0} = 2'b00;
      for (int k = 0; k < DB; k++) begin
         @(negedge clk);
         chk(aux_sbu_a == 1'b1, "R9 hold", aux_sbu_a, 1);
      end
      @(negedge clk);
      chk(aux_sbu_a == 1'b0, "R9 off", aux_sbu_a, 0);
      // restart inside window
      {reg_ctl1, reg_ctl0} = 2'b10;
      @(negedge clk);
      chk(aux_sbu_a == 1'b1, "R9 on", aux_sbu_a, 1);
      {reg_ctl1, reg_ctl0} = 2'b00;
      repeat (3) @(negedge clk);
      {reg_ctl1, reg_ctl0} = 2'b10;
      @(negedge clk);
      {reg_ctl1, reg_ctl0} = 2'b00;
      for (int k = 0; k < DB; k++) begin
         @(negedge clk);
         chk(aux_sbu_a == 1'b1, "R9 restart", aux_sbu_a, 1);
      end
      @(negedge clk);
      chk(aux_sbu_a == 1'b0, "R9 restart off", aux_sbu_a, 0);

      // R6: aux on side B when flipped
      flip_pin = 1'b1;
      repeat (4) @(negedge clk);
      {reg_ctl1, reg_ctl0} = 2'b10;
      @(negedge clk);
      chk(!aux_sbu_a && aux_sbu_b, "R6 aux", {aux_sbu_a, aux_sbu_b}, 2'b01);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule